// File: doc/BRIEF.md
# Codec Host Transfer Mode Controller

This block sits between a host bus and the sample buffers of a stereo audio converter. The host bus is byte-wide: an 8-bit data bus, a 2-bit port address, an active-low chip select and active-low read and write strobes. It also carries one request/acknowledge handshake pair for playback and a second pair for capture. On its own side of the block, each direction holds a single-sample buffer. A sample-tick input marks the moment the converter consumes a playback sample and delivers a capture sample.

Software selects the mode for each direction on its own, through an indirectly addressed register file. A direction can be off, moved by DMA handshakes, or moved by programmed I/O through a data port. Playback can run in one mode while capture runs in the other. Register traffic is valid only when chip select is low and both acknowledge lines are high. Acknowledge-qualified cycles only move sample bytes. All host strobes are asynchronous and pass through a two-stage synchronizer. There is no FIFO. If a buffer has not been serviced by the time the tick arrives, the block raises a sticky error flag.

Top module: `codec_xfer_ctrl`

## Requirements
- R1: After reset, both request outputs are low, the playback word output is zero, and the status port reads 0x00.
- R2: Writing port 0 selects a register index. Writing port 1 stores a byte in the selected register. Reading port 1 returns that byte, and reading port 0 returns the index. Register 0 is the mode register: bit0 playback enable, bit1 capture enable, bit2 playback PIO, bit3 capture PIO.
- R3: Playback PIO is active only when playback enable and playback PIO are both set. Only then does a port 3 write load the playback buffer, and the playback request stays low while it is active.
- R4: Capture PIO is active only when capture enable and capture PIO are both set. Only then does a port 3 read return the next capture byte and consume it. Otherwise a port 3 read returns 0x00 and leaves the pending data in place.
- R5: With playback enable set and playback PIO clear, the playback request is high while the buffer is not full. It falls once the final byte of the sample has been written under playback acknowledge.
- R6: With capture enable set and capture PIO clear, the capture request is high while capture bytes are unread. It falls once the final byte has been read under capture acknowledge.
- R7: Bytes move least significant byte first. Playback byte k fills bits 8k+7:8k of the word that a tick presents on the playback word output. Capture reads return byte 0 first.
- R8: One direction can transfer by PIO while the other transfers by DMA, and the two do not disturb each other.
- R9: A write made with an acknowledge low never changes the register file, even when chip select is low.
- R10: A tick while playback is enabled and the buffer is not full sets sticky status bit0 (underrun), discards the partial sample, and leaves the playback word unchanged. Writing 1 to bit0 of port 2 clears the flag.
- R11: A tick while capture is enabled and capture bytes are still unread sets sticky status bit1 (overrun), which is cleared by writing 1 to bit1 of port 2. Status bit2 shows a full playback buffer, and bit3 shows unread capture bytes.
- R12: A disabled direction holds its request low, ignores its acknowledge, flushes its buffer, and never raises its error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 1 | Chip select, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_port | input | 2 | Port address: 0 index, 1 data, 2 status, 3 PIO sample |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| play_ack_n | input | 1 | Playback DMA acknowledge, active low |
| cap_ack_n | input | 1 | Capture DMA acknowledge, active low |
| play_req | output | 1 | Playback DMA request |
| cap_req | output | 1 | Capture DMA request |
| sample_tick | input | 1 | One-cycle converter sample strobe |
| cap_word_i | input | 16 | Capture sample from the converter |
| play_word_o | output | 16 | Playback sample to the converter |

## Verification
The strobe, select, acknowledge, address and data lines pass through two synchronizer stages and one edge stage. Their effects therefore land on the third rising edge after a strobe is released, and read data settles two edges after the select or acknowledge falls. The bench holds every strobe low for four cycles before it samples read data. It then waits four cycles after each release before it looks at requests or status. A tick acts on the very next edge, so the bench samples tick results one cycle later at the falling edge. No host cycle is placed near a tick, which avoids same-cycle collisions.

// File: rtl/codec_xfer_pkg.sv
package codec_xfer_pkg;

  typedef enum logic [1:0] {
    PORT_INDEX  = 2'd0,
    PORT_DATA   = 2'd1,
    PORT_STATUS = 2'd2,
    PORT_PIO    = 2'd3
  } port_e;

  typedef struct packed {
    logic cap_pio;
    logic play_pio;
    logic cap_en;
    logic play_en;
  } mode_t;

  // Direction moves data by programmed I/O.
  function automatic logic pio_live(input logic en, input logic pio);
    return en & pio;
  endfunction

  // Direction moves data by request/acknowledge handshakes.
  function automatic logic dma_live(input logic en, input logic pio);
    return en & ~pio;
  endfunction

  // Byte slot next read from a capture word, given bytes still pending.
  function automatic int drain_slot(input int pending, input int nbytes);
    return nbytes - pending;
  endfunction

  // Status byte assembly.
  function automatic logic [7:0] pack_status(input logic underrun, input logic overrun,
                                              input logic play_full, input logic cap_pend);
    return {4'b0000, cap_pend, play_full, overrun, underrun};
  endfunction

endpackage

// File: rtl/codec_host_sync.sv
module codec_host_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
      last_q <= RST_VAL;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign rise_o = sync_q & ~last_q;
endmodule

// File: rtl/codec_regs.sv
module codec_regs
  import codec_xfer_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  port_e      port_i,
  input  logic [7:0] wdata_i,
  input  logic       set_underrun_i,
  input  logic       set_overrun_i,
  input  logic       play_full_i,
  input  logic       cap_pend_i,
  output mode_t      mode_o,
  output logic [7:0] rdata_o,
  output logic       underrun_o,
  output logic       overrun_o
);
  logic [IDX_W-1:0] index_q;
  logic [7:0]       regs_q [NUM_REGS];
  logic             underrun_q, overrun_q;
  logic             clr_underrun, clr_overrun;

  assign clr_underrun = wr_i && port_i == PORT_STATUS && wdata_i[0];
  assign clr_overrun  = wr_i && port_i == PORT_STATUS && wdata_i[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= '0;
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= 8'h00;
    end else if (wr_i) begin
      if (port_i == PORT_INDEX) index_q <= wdata_i[IDX_W-1:0];
      if (port_i == PORT_DATA && int'(index_q) < NUM_REGS) regs_q[index_q] <= wdata_i;
    end
  end

  // Set wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      underrun_q <= 1'b0;
      overrun_q  <= 1'b0;
    end else begin
      if (set_underrun_i)    underrun_q <= 1'b1;
      else if (clr_underrun) underrun_q <= 1'b0;
      if (set_overrun_i)     overrun_q  <= 1'b1;
      else if (clr_overrun)  overrun_q  <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    case (port_i)
      PORT_INDEX:  rdata_o = 8'(index_q);
      PORT_DATA:   rdata_o = (int'(index_q) < NUM_REGS) ? regs_q[index_q] : 8'h00;
      PORT_STATUS: rdata_o = pack_status(underrun_q, overrun_q, play_full_i, cap_pend_i);
      default:     rdata_o = 8'h00;
    endcase
  end

  assign mode_o     = mode_t'(regs_q[0][3:0]);
  assign underrun_o = underrun_q;
  assign overrun_o  = overrun_q;
endmodule

// File: rtl/codec_play_buf.sv
module codec_play_buf #(
  parameter int NBYTES = 2,
  localparam int CNT_W = $clog2(NBYTES + 1),
  localparam int WORD_W = 8 * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              byte_we_i,
  input  logic [7:0]        byte_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o,
  output logic              underrun_o,
  output logic              fill_done_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NBYTES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NBYTES - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] acc_q, word_q;

  assign full_o = (cnt_q == FULL_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      word_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (full_o) word_q <= acc_q;
      cnt_q <= '0;
    end else if (byte_we_i && !full_o) begin
      acc_q[8*cnt_q +: 8] <= byte_i;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word_o      = word_q;
  assign underrun_o  = en_i & tick_i & ~full_o;
  assign fill_done_o = en_i & ~tick_i & byte_we_i & (cnt_q == LAST_CNT);
endmodule

// File: rtl/codec_cap_buf.sv
module codec_cap_buf
  import codec_xfer_pkg::*;
#(
  parameter int NBYTES = 2,
  localparam int CNT_W = $clog2(NBYTES + 1),
  localparam int WORD_W = 8 * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              byte_re_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [7:0]        byte_o,
  output logic              pending_o,
  output logic              overrun_o,
  output logic              drain_done_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NBYTES);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] word_q;
  int                slot;

  assign pending_o = (cnt_q != '0);
  assign slot      = drain_slot(int'(cnt_q), NBYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      word_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      word_q <= word_i;
      cnt_q  <= FULL_CNT;
    end else if (byte_re_i && pending_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    byte_o = 8'h00;
    if (pending_o && slot < NBYTES) byte_o = word_q[8*slot +: 8];
  end

  assign overrun_o    = en_i & tick_i & pending_o;
  assign drain_done_o = en_i & ~tick_i & byte_re_i & (cnt_q == ONE_CNT);
endmodule

// File: rtl/codec_xfer_ctrl.sv
module codec_xfer_ctrl
  import codec_xfer_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int NBYTES = 2,
  localparam int WORD_W = 8 * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [1:0]        host_port,
  input  logic [7:0]        host_din,
  output logic [7:0]        host_dout,
  input  logic              play_ack_n,
  input  logic              cap_ack_n,
  output logic              play_req,
  output logic              cap_req,
  input  logic              sample_tick,
  input  logic [WORD_W-1:0] cap_word_i,
  output logic [WORD_W-1:0] play_word_o
);
  // Control lines: {cap_ack_n, play_ack_n, wr_n, rd_n, cs_n}, idle high.
  logic [4:0] ctl_sync, ctl_rise;
  logic [9:0] bus_sync, bus_rise;

  codec_host_sync #(.W(5), .RST_VAL(5'b11111)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({cap_ack_n, play_ack_n, host_wr_n, host_rd_n, host_cs_n}),
    .sync_o(ctl_sync), .rise_o(ctl_rise));

  codec_host_sync #(.W(10), .RST_VAL(10'd0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({host_port, host_din}),
    .sync_o(bus_sync), .rise_o(bus_rise));

  // Named events for the checker.
  logic  rd_done, wr_done;
  logic  reg_cycle, play_dma_cyc, cap_dma_cyc;
  logic  play_dma_mode, play_pio_mode, cap_dma_mode, cap_pio_mode;
  logic  play_byte_we, cap_byte_re, reg_wr;
  logic  play_full, cap_pend, play_underrun, cap_overrun;
  logic  play_fill_done, cap_drain_done;
  logic  underrun_flag, overrun_flag;
  logic  [7:0] s_data, reg_rdata, cap_byte;
  port_e s_port;
  mode_t mode;

  assign rd_done = ctl_rise[1];
  assign wr_done = ctl_rise[2];
  assign s_data  = bus_sync[7:0];
  assign s_port  = port_e'(bus_sync[9:8]);

  assign play_dma_cyc = ~ctl_sync[3];
  assign cap_dma_cyc  = ~ctl_sync[4];
  assign reg_cycle    = ~ctl_sync[0] & ctl_sync[3] & ctl_sync[4];

  assign play_dma_mode = dma_live(mode.play_en, mode.play_pio);
  assign play_pio_mode = pio_live(mode.play_en, mode.play_pio);
  assign cap_dma_mode  = dma_live(mode.cap_en, mode.cap_pio);
  assign cap_pio_mode  = pio_live(mode.cap_en, mode.cap_pio);

  assign play_byte_we = wr_done & ((play_dma_cyc & play_dma_mode) |
                                   (reg_cycle & s_port == PORT_PIO & play_pio_mode));
  assign cap_byte_re  = rd_done & ((cap_dma_cyc & cap_dma_mode) |
                                   (reg_cycle & s_port == PORT_PIO & cap_pio_mode));
  assign reg_wr       = wr_done & reg_cycle & (s_port != PORT_PIO);

  codec_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .port_i(s_port), .wdata_i(s_data),
    .set_underrun_i(play_underrun), .set_overrun_i(cap_overrun),
    .play_full_i(play_full), .cap_pend_i(cap_pend),
    .mode_o(mode), .rdata_o(reg_rdata),
    .underrun_o(underrun_flag), .overrun_o(overrun_flag));

  codec_play_buf #(.NBYTES(NBYTES)) u_play (
    .clk(clk), .rst_n(rst_n), .en_i(mode.play_en), .tick_i(sample_tick),
    .byte_we_i(play_byte_we), .byte_i(s_data), .word_o(play_word_o),
    .full_o(play_full), .underrun_o(play_underrun), .fill_done_o(play_fill_done));

  codec_cap_buf #(.NBYTES(NBYTES)) u_cap (
    .clk(clk), .rst_n(rst_n), .en_i(mode.cap_en), .tick_i(sample_tick),
    .byte_re_i(cap_byte_re), .word_i(cap_word_i), .byte_o(cap_byte),
    .pending_o(cap_pend), .overrun_o(cap_overrun), .drain_done_o(cap_drain_done));

  assign play_req = play_dma_mode & ~play_full;
  assign cap_req  = cap_dma_mode & cap_pend;

  always_comb begin
    host_dout = 8'h00;
    if (cap_dma_cyc) begin
      if (cap_dma_mode) host_dout = cap_byte;
    end else if (reg_cycle) begin
      if (s_port == PORT_PIO) host_dout = cap_pio_mode ? cap_byte : 8'h00;
      else                    host_dout = reg_rdata;
    end
  end
endmodule

// File: rtl/codec_xfer_ctrl_chk.sv
module codec_xfer_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic play_en,
  input logic cap_en,
  input logic play_pio,
  input logic cap_pio,
  input logic play_req,
  input logic cap_req,
  input logic tick,
  input logic play_full,
  input logic cap_pend,
  input logic reg_wr,
  input logic play_dma_cyc,
  input logic cap_dma_cyc,
  input logic underrun_flag,
  input logic overrun_flag,
  input logic play_fill_done,
  input logic cap_drain_done
);
  assert_play_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !play_en |-> !play_req);
  assert_cap_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |-> !cap_req);
  assert_play_pio_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    play_pio |-> !play_req);
  assert_cap_pio_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pio |-> !cap_req);
  assert_play_req_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    play_fill_done |=> !play_req);
  assert_cap_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_drain_done |=> !cap_req);
  assert_dma_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (play_dma_cyc || cap_dma_cyc) |-> !reg_wr);
  assert_underrun_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && play_en && !play_full) |=> underrun_flag);
  assert_overrun_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cap_en && cap_pend) |=> overrun_flag);
endmodule

bind codec_xfer_ctrl codec_xfer_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .play_en(mode.play_en), .cap_en(mode.cap_en),
  .play_pio(mode.play_pio), .cap_pio(mode.cap_pio),
  .play_req(play_req), .cap_req(cap_req), .tick(sample_tick),
  .play_full(play_full), .cap_pend(cap_pend), .reg_wr(reg_wr),
  .play_dma_cyc(play_dma_cyc), .cap_dma_cyc(cap_dma_cyc),
  .underrun_flag(underrun_flag), .overrun_flag(overrun_flag),
  .play_fill_done(play_fill_done), .cap_drain_done(cap_drain_done));

// File: tb/codec_xfer_ctrl_bench.sv
`timescale 1ns/1ps
module codec_xfer_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, pack_n = 1'b1, cack_n = 1'b1;
  logic [1:0] port = 2'd0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic play_req, cap_req, tick = 1'b0;
  logic [15:0] cap_word = 16'h0000;
  logic [15:0] play_word;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t exp_q[$];
  event rd_ev;

  always #2 clk = ~clk;

  codec_xfer_ctrl u_codec_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
    .host_port(port), .host_din(din), .host_dout(dout),
    .play_ack_n(pack_n), .cap_ack_n(cack_n), .play_req(play_req), .cap_req(cap_req),
    .sample_tick(tick), .cap_word_i(cap_word), .play_word_o(play_word));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard whenever a read is held stable.
  initial begin
    forever begin
      @(rd_ev);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, {24'h0, dout}, {24'h0, e.val});
      end
    end
  end

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // kind: 0 register/PIO via chip select, 1 playback ack, 2 capture ack
  task automatic host_wr(input logic [1:0] p, input logic [7:0] d, input int kind);
    @(negedge clk);
    port = p; din = d;
    if (kind == 1) pack_n = 1'b0; else if (kind == 2) cack_n = 1'b0;
    cs_n = 1'b0;
    wait_clks(1);
    wr_n = 1'b0;
    wait_clks(4);
    wr_n = 1'b1;
    wait_clks(4);
    cs_n = 1'b1; pack_n = 1'b1; cack_n = 1'b1;
    wait_clks(3);
  endtask

  task automatic host_rd(input logic [1:0] p, input logic [7:0] expv, input int kind,
                         input string tag);
    exp_t e;
    @(negedge clk);
    port = p;
    if (kind == 2) cack_n = 1'b0; else cs_n = 1'b0;
    wait_clks(1);
    rd_n = 1'b0;
    wait_clks(4);
    e.val = expv; e.tag = tag;
    exp_q.push_back(e);
    -> rd_ev;
    wait_clks(1);
    rd_n = 1'b1;
    wait_clks(4);
    cs_n = 1'b1; cack_n = 1'b1;
    wait_clks(3);
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    wait_clks(2);
  endtask

  initial begin
    wait_clks(3);
    rst_n = 1'b1;
    wait_clks(3);

    // R1 reset state
    chk("R1 play_req", {31'h0, play_req}, 0);
    chk("R1 cap_req", {31'h0, cap_req}, 0);
    chk("R1 play_word", {16'h0, play_word}, 0);
    host_rd(2'd2, 8'h00, 0, "R1 status");

    // R2 indirect register file
    host_wr(2'd0, 8'h03, 0); host_wr(2'd1, 8'hA5, 0);
    host_wr(2'd0, 8'h05, 0); host_wr(2'd1, 8'h3C, 0);
    host_rd(2'd0, 8'h05, 0, "R2 index readback");
    host_rd(2'd1, 8'h3C, 0, "R2 data idx5");
    host_wr(2'd0, 8'h03, 0);
    host_rd(2'd1, 8'hA5, 0, "R2 data idx3");

    // R3 PIO bit without enable: port 3 write ignored
    host_wr(2'd0, 8'h00, 0); host_wr(2'd1, 8'h04, 0);
    host_wr(2'd3, 8'h11, 0);
    host_wr(2'd3, 8'h22, 0);
    host_rd(2'd2, 8'h00, 0, "R3 inactive PIO leaves buffer empty");
    chk("R3 no request", {31'h0, play_req}, 0);

    // R8 playback PIO + capture DMA (mode 0x07)
    host_wr(2'd0, 8'h00, 0); host_wr(2'd1, 8'h07, 0);
    chk("R3 pio mode no request", {31'h0, play_req}, 0);
    chk("R6 no data no request", {31'h0, cap_req}, 0);
    host_wr(2'd3, 8'h34, 0);
    host_wr(2'd3, 8'h12, 0);
    host_rd(2'd2, 8'h04, 0, "R3 buffer full after PIO");
    cap_word = 16'hBEEF;
    pulse_tick();
    chk("R7 play word order", {16'h0, play_word}, 32'h1234);
    chk("R6 capture request", {31'h0, cap_req}, 1);
    host_rd(2'd0, 8'hEF, 2, "R7 capture low byte first");
    chk("R6 request held mid-sample", {31'h0, cap_req}, 1);
    host_rd(2'd0, 8'hBE, 2, "R8 capture high byte");
    chk("R6 request drops", {31'h0, cap_req}, 0);

    // R10/R11 flags
    host_wr(2'd0, 8'h05, 0);
    pulse_tick();
    host_rd(2'd2, 8'h09, 0, "R10 underrun set");
    chk("R10 word unchanged", {16'h0, play_word}, 32'h1234);
    pulse_tick();
    host_rd(2'd2, 8'h0B, 0, "R11 overrun set");
    host_wr(2'd2, 8'h03, 0);
    host_rd(2'd2, 8'h08, 0, "R11 flags cleared");

    // R4/R5/R9 play DMA + capture PIO (mode 0x0B)
    host_wr(2'd0, 8'h00, 0); host_wr(2'd1, 8'h0B, 0); host_wr(2'd0, 8'h05, 0);
    host_rd(2'd3, 8'hEF, 0, "R4 PIO low byte");
    host_rd(2'd3, 8'hBE, 0, "R4 PIO high byte");
    host_rd(2'd2, 8'h00, 0, "R4 capture drained");
    chk("R5 request raised", {31'h0, play_req}, 1);
    host_wr(2'd1, 8'h77, 1);
    chk("R5 request held mid-sample", {31'h0, play_req}, 1);
    host_wr(2'd1, 8'h66, 1);
    chk("R5 request drops", {31'h0, play_req}, 0);
    host_rd(2'd1, 8'h3C, 0, "R9 DMA write left register");
    pulse_tick();
    chk("R5 DMA word", {16'h0, play_word}, 32'h6677);

    // R4 negative: capture in DMA mode, port 3 read ignored (mode 0x02)
    host_wr(2'd0, 8'h00, 0); host_wr(2'd1, 8'h02, 0);
    chk("R12 disabled play no request", {31'h0, play_req}, 0);
    host_rd(2'd3, 8'h00, 0, "R4 inactive PIO reads zero");
    host_rd(2'd2, 8'h08, 0, "R4 pending kept");

    // R12 all disabled
    host_wr(2'd1, 8'h00, 0);
    chk("R12 cap no request", {31'h0, cap_req}, 0);
    host_wr(2'd0, 8'h00, 1);
    host_wr(2'd0, 8'h00, 1);
    host_rd(2'd2, 8'h00, 0, "R12 ack ignored");
    pulse_tick();
    host_rd(2'd2, 8'h00, 0, "R12 no flags when disabled");
    chk("R12 word unchanged", {16'h0, play_word}, 32'h6677);

    wait_clks(5);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule